// File: doc/BRIEF.md
# System-Side Timeslot Timing Generator

This block produces all read-side timing for a receive elastic store that feeds a T1 frame onto a backplane. The backplane runs either at the native 193-bit frame or at a wider 256-bit frame of 32 eight-bit timeslots. One bit counter, aligned to the backplane frame sync, gives the current bit position. From it the block decodes the channel index, the bit within the channel, the framing-bit slot, a channel clock and a least-significant-bit strobe.

The block also gives the buffer a read position and a read-advance strobe. In the wide mode the framing bit is dropped and a gate tells the output stage to drive ones in the unused timeslots. With the parallel backplane option the read position runs eight bit times ahead of the backplane position, so that an external converter can capture a whole byte.

A frame counter follows the multiframe, which is 12 frames in superframe mode and 24 frames in extended superframe mode. Slip reports from the buffer shift this counter forward or back by one frame. The multiframe pulse therefore stays aligned with the data that actually leaves the store.

Top module: `slot_timer`

## Requirements
- R1: While `rst_n` is low, `bit_pos` and `frame_idx` read 0 and `mf_pulse` reads 0.
- R2: `bit_pos` steps by one on every clock. It returns to 0 after 192 when `wide_rate`=0, and after 255 when `wide_rate`=1.
- R3: A clock edge that samples `fsync` high, when the previous edge sampled it low, sets `bit_pos` to 0. Holding `fsync` high does not realign the counter again.
- R4: With `wide_rate`=0, position 0 is the framing bit (`fbit_slot`=1, `chan_idx`=0, `chan_bit`=0). Position p in 1..192 gives `chan_idx`=(p-1)/8 and `chan_bit`=(p-1)%8, where bit 0 is the MSB.
- R5: With `wide_rate`=1, `fbit_slot` stays 0 and position 0 is `chan_idx`=31, `chan_bit`=7. Position p in 1..255 gives `chan_idx`=(p-1)/8 and `chan_bit`=(p-1)%8, so channel 0's MSB sits one bit after the frame start.
- R6: `lsb_strobe` is 1 exactly when `chan_bit`=7 outside the framing slot. `chan_clk` is 1 exactly when `chan_bit`<4 outside the framing slot, so it rises on every channel boundary.
- R7: `rd_pos` equals `bit_pos` when `par_mode`=0. When `par_mode`=1 it equals (`bit_pos`+8) modulo the frame length.
- R8: With `wide_rate`=0, `rd_adv`=1 and `idle_ones`=0 on every bit. With `wide_rate`=1, `rd_adv`=1 only when `rd_pos` lies in 1..192, and `idle_ones` is its complement.
- R9: `frame_idx` advances by one whenever `bit_pos` returns to 0, whether by wrap or by realignment. It counts modulo 12 when `ext_mf`=0 and modulo 24 when `ext_mf`=1.
- R10: A one-cycle `slip_skip` adds one to `frame_idx` and a one-cycle `slip_rep` subtracts one, both modulo the multiframe length. The two together cancel. Any slip adjustment adds to the frame-start step of the same edge.
- R11: `mf_pulse` rises together with a frame start that brings `frame_idx` to 0 and stays high for exactly 65 clocks. A slip that moves `frame_idx` to 0 away from a frame start does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Backplane frame sync; its rising edge aligns the frame |
| wide_rate | input | 1 | 0: 193-bit frame, 1: 256-bit frame |
| par_mode | input | 1 | 1: read position runs eight bits ahead |
| ext_mf | input | 1 | 0: 12-frame multiframe, 1: 24-frame multiframe |
| slip_skip | input | 1 | Buffer dropped a frame; frame count +1 |
| slip_rep | input | 1 | Buffer repeated a frame; frame count -1 |
| bit_pos | output | 9 | Bit position inside the backplane frame |
| chan_idx | output | 5 | Channel index, 0-based |
| chan_bit | output | 3 | Bit within channel, 0 = MSB |
| fbit_slot | output | 1 | Current bit is the framing bit |
| chan_clk | output | 1 | Channel clock, high for the first half of each channel |
| lsb_strobe | output | 1 | High during each channel's last bit |
| rd_pos | output | 9 | Frame position the buffer should present |
| rd_adv | output | 1 | Buffer read pointer should advance this bit |
| idle_ones | output | 1 | Output stage forces a one this bit |
| frame_idx | output | 5 | Slip-compensated frame number in the multiframe |
| mf_pulse | output | 1 | Multiframe marker, 65 clocks long |

## Verification
Every decoded output is combinational from the registered bit position. It therefore follows an input change at the very next rising edge. A frame-sync edge driven between edges shows `bit_pos`=0 one clock later, and the bench samples every output on the falling edge that follows the edge that caused the change. Slip inputs are held for one clock, so `frame_idx` is compared one clock after they drop. The multiframe pulse is seen high on the falling edge right after the frame start into frame 0, and the bench counts its high samples until the first low one. Walks over whole frames compare each position against the bench's own slot arithmetic for both rates and both read alignments.

// File: rtl/slot_timer_pkg.sv
package slot_timer_pkg;
   localparam int POS_W = 9;   // bit position inside the wide frame
   localparam int CH_W  = 5;   // channel index
   localparam int BIT_W = 3;   // bit within channel
   localparam int FR_W  = 5;   // frame index inside the multiframe

   typedef struct packed {
      logic [CH_W-1:0]  chan;
      logic [BIT_W-1:0] bitn;
      logic             fbit;
   } slot_t;
endpackage

// File: rtl/st_bit_counter.sv
module st_bit_counter
   import slot_timer_pkg::*;
#(
   parameter int NARROW_LEN = 193,
   parameter int WIDE_LEN   = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync,
   input  logic             wide,
   output logic [POS_W-1:0] pos,
   output logic             frame_start
);
   localparam logic [POS_W-1:0] N_LAST = POS_W'(NARROW_LEN - 1);
   localparam logic [POS_W-1:0] W_LAST = POS_W'(WIDE_LEN - 1);

   logic             fsync_q;
   logic             rise;
   logic [POS_W-1:0] last;

   assign last        = wide ? W_LAST : N_LAST;
   assign rise        = fsync & ~fsync_q;
   // frame start: realignment or end of frame (also catches a shortened frame)
   assign frame_start = rise | (pos >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsync_q <= 1'b0;
         pos     <= '0;
      end else begin
         fsync_q <= fsync;
         pos     <= frame_start ? '0 : pos + 1'b1;
      end
   end
endmodule

// File: rtl/st_slot_decode.sv
module st_slot_decode
   import slot_timer_pkg::*;
#(
   parameter int NARROW_LEN = 193,
   parameter int WIDE_LEN   = 256,
   parameter int CH_BITS    = 8,
   parameter int DATA_CHANS = 24,
   parameter int LOOKAHEAD  = 8
) (
   input  logic [POS_W-1:0] pos,
   input  logic             wide,
   input  logic             par,
   output slot_t            slot,
   output logic             chan_clk,
   output logic             lsb,
   output logic [POS_W-1:0] rd_pos,
   output logic             rd_adv,
   output logic             idle
);
   localparam int DATA_BITS  = DATA_CHANS * CH_BITS;
   localparam int HALF       = CH_BITS / 2;
   localparam int WIDE_CHANS = WIDE_LEN / CH_BITS;

   logic [POS_W-1:0] seq;   // position minus one: data bit sequence

   assign seq = pos - 1'b1;

   always_comb begin
      slot = '0;
      if (pos == '0) begin
         if (wide) begin
            slot.chan = CH_W'(WIDE_CHANS - 1);
            slot.bitn = BIT_W'(CH_BITS - 1);
         end else begin
            slot.fbit = 1'b1;
         end
      end else begin
         slot.chan = CH_W'(seq >> BIT_W);
         slot.bitn = seq[BIT_W-1:0];
      end
   end

   assign chan_clk = !slot.fbit && (slot.bitn < BIT_W'(HALF));
   assign lsb      = !slot.fbit && (slot.bitn == BIT_W'(CH_BITS - 1));

   generate
      if (LOOKAHEAD == 0) begin : g_direct
         assign rd_pos = pos;
      end else begin : g_ahead
         logic [POS_W:0] sum;
         logic [POS_W:0] len;
         assign len    = wide ? (POS_W+1)'(WIDE_LEN) : (POS_W+1)'(NARROW_LEN);
         assign sum    = {1'b0, pos} + (POS_W+1)'(LOOKAHEAD);
         assign rd_pos = par ? POS_W'((sum >= len) ? sum - len : sum) : pos;
      end
   endgenerate

   assign rd_adv = !wide || ((rd_pos != '0) && (rd_pos <= POS_W'(DATA_BITS)));
   assign idle   = !rd_adv;
endmodule

// File: rtl/st_frame_counter.sv
module st_frame_counter
   import slot_timer_pkg::*;
#(
   parameter int SF_FRAMES  = 12,
   parameter int ESF_FRAMES = 24
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ext,
   input  logic            start,
   input  logic            skip,
   input  logic            rep,
   output logic [FR_W-1:0] fidx,
   output logic            mf_trig
);
   localparam int S_W = FR_W + 2;

   logic [S_W-1:0]  mf;
   logic [S_W-1:0]  cur;
   logic [S_W-1:0]  base;
   logic [S_W-1:0]  sum;
   logic [S_W-1:0]  wrapped;
   logic [FR_W-1:0] nxt;

   assign mf   = ext ? S_W'(ESF_FRAMES) : S_W'(SF_FRAMES);
   assign cur  = S_W'(fidx);
   // after a switch to the shorter multiframe the index may be out of range
   assign base = (cur >= mf) ? cur - mf : cur;
   // offset by one multiframe so that a backward slip never goes negative
   assign sum  = base + mf + S_W'(start) + S_W'(skip) - S_W'(rep);
   assign wrapped = (sum >= (mf << 1)) ? sum - (mf << 1) :
                    (sum >= mf)        ? sum - mf        : sum;
   assign nxt     = FR_W'(wrapped);
   assign mf_trig = start && (nxt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fidx <= '0;
      else        fidx <= nxt;
   end
endmodule

// File: rtl/st_mf_pulse.sv
module st_mf_pulse #(
   parameter int PULSE_CYC = 65
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic pulse
);
   localparam int CW = $clog2(PULSE_CYC + 1);

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= '0;
      else if (trig)           remain <= CW'(PULSE_CYC);
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   assign pulse = (remain != '0);
endmodule

// File: rtl/slot_timer.sv
module slot_timer
   import slot_timer_pkg::*;
#(
   parameter int NARROW_LEN = 193,
   parameter int WIDE_LEN   = 256,
   parameter int CH_BITS    = 8,
   parameter int DATA_CHANS = 24,
   parameter int LOOKAHEAD  = 8,
   parameter int SF_FRAMES  = 12,
   parameter int ESF_FRAMES = 24,
   parameter int PULSE_CYC  = 65
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync,
   input  logic             wide_rate,
   input  logic             par_mode,
   input  logic             ext_mf,
   input  logic             slip_skip,
   input  logic             slip_rep,
   output logic [POS_W-1:0] bit_pos,
   output logic [CH_W-1:0]  chan_idx,
   output logic [BIT_W-1:0] chan_bit,
   output logic             fbit_slot,
   output logic             chan_clk,
   output logic             lsb_strobe,
   output logic [POS_W-1:0] rd_pos,
   output logic             rd_adv,
   output logic             idle_ones,
   output logic [FR_W-1:0]  frame_idx,
   output logic             mf_pulse
);
   // elaboration-time parameter checks
   generate
      if (NARROW_LEN != DATA_CHANS * CH_BITS + 1) begin : g_bad_narrow
         $error("narrow frame must hold the data channels plus one framing bit");
      end
      if ((WIDE_LEN <= NARROW_LEN) || (WIDE_LEN % CH_BITS != 0)) begin : g_bad_wide
         $error("wide frame must be longer and a whole number of channels");
      end
      if ((1 << BIT_W) != CH_BITS) begin : g_bad_chbits
         $error("channel width must match the bit index width");
      end
      if ((WIDE_LEN > (1 << POS_W)) || (WIDE_LEN / CH_BITS > (1 << CH_W))) begin : g_bad_pos
         $error("position or channel index too narrow");
      end
      if ((SF_FRAMES < 1) || (ESF_FRAMES < SF_FRAMES) || (ESF_FRAMES > 2 * SF_FRAMES) ||
          (ESF_FRAMES > (1 << FR_W))) begin : g_bad_mf
         $error("multiframe lengths out of range");
      end
      if ((LOOKAHEAD < 0) || (LOOKAHEAD >= NARROW_LEN) || (PULSE_CYC < 1)) begin : g_bad_misc
         $error("lookahead or pulse length out of range");
      end
   endgenerate

   logic  frame_start;
   logic  mf_trig;
   slot_t slot;

   st_bit_counter #(
      .NARROW_LEN (NARROW_LEN),
      .WIDE_LEN   (WIDE_LEN)
   ) u_bits (
      .clk         (clk),
      .rst_n       (rst_n),
      .fsync       (fsync),
      .wide        (wide_rate),
      .pos         (bit_pos),
      .frame_start (frame_start)
   );

   st_slot_decode #(
      .NARROW_LEN (NARROW_LEN),
      .WIDE_LEN   (WIDE_LEN),
      .CH_BITS    (CH_BITS),
      .DATA_CHANS (DATA_CHANS),
      .LOOKAHEAD  (LOOKAHEAD)
   ) u_decode (
      .pos      (bit_pos),
      .wide     (wide_rate),
      .par      (par_mode),
      .slot     (slot),
      .chan_clk (chan_clk),
      .lsb      (lsb_strobe),
      .rd_pos   (rd_pos),
      .rd_adv   (rd_adv),
      .idle     (idle_ones)
   );

   assign chan_idx  = slot.chan;
   assign chan_bit  = slot.bitn;
   assign fbit_slot = slot.fbit;

   st_frame_counter #(
      .SF_FRAMES  (SF_FRAMES),
      .ESF_FRAMES (ESF_FRAMES)
   ) u_frames (
      .clk     (clk),
      .rst_n   (rst_n),
      .ext     (ext_mf),
      .start   (frame_start),
      .skip    (slip_skip),
      .rep     (slip_rep),
      .fidx    (frame_idx),
      .mf_trig (mf_trig)
   );

   st_mf_pulse #(
      .PULSE_CYC (PULSE_CYC)
   ) u_mf (
      .clk   (clk),
      .rst_n (rst_n),
      .trig  (mf_trig),
      .pulse (mf_pulse)
   );
endmodule

// File: rtl/slot_timer_chk.sv
module slot_timer_chk
   import slot_timer_pkg::*;
#(
   parameter int NARROW_LEN = 193,
   parameter int WIDE_LEN   = 256,
   parameter int SF_FRAMES  = 12,
   parameter int ESF_FRAMES = 24,
   parameter int PULSE_CYC  = 65
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fsync,
   input logic             wide_rate,
   input logic             par_mode,
   input logic             ext_mf,
   input logic [POS_W-1:0] bit_pos,
   input logic [BIT_W-1:0] chan_bit,
   input logic             lsb_strobe,
   input logic [POS_W-1:0] rd_pos,
   input logic             rd_adv,
   input logic             idle_ones,
   input logic [FR_W-1:0]  frame_idx,
   input logic             mf_pulse
);
   localparam int RW = $clog2(PULSE_CYC + 2) + 1;

   logic [POS_W-1:0] lastp;
   logic [FR_W-1:0]  lim;
   logic [RW-1:0]    run_len;

   assign lastp = wide_rate ? POS_W'(WIDE_LEN - 1) : POS_W'(NARROW_LEN - 1);
   assign lim   = ext_mf ? FR_W'(ESF_FRAMES) : FR_W'(SF_FRAMES);

   // consecutive high samples of the multiframe pulse before the current one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          run_len <= '0;
      else if (!mf_pulse)                  run_len <= '0;
      else if (run_len != {RW{1'b1}})      run_len <= run_len + 1'b1;
   end

   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !($past(fsync) && !$past(fsync, 2)) && ($past(bit_pos) < $past(lastp)))
      |-> (bit_pos == $past(bit_pos) + 1'b1));

   assert_realign_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(fsync) && !$past(fsync, 2)) |-> (bit_pos == '0));

   assert_lsb_then_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lsb_strobe && !fsync) |=> (!$stable(wide_rate) || (chan_bit == '0)));

   assert_serial_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !par_mode |-> (rd_pos == bit_pos));

   assert_narrow_reads_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wide_rate |-> (rd_adv && !idle_ones));

   assert_frame_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $stable(ext_mf)) |-> (frame_idx < lim));

   assert_mf_align_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mf_pulse) |-> ((bit_pos == '0) && (frame_idx == '0)));

   assert_mf_length_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mf_pulse) |-> (run_len >= RW'(PULSE_CYC)));
endmodule

bind slot_timer slot_timer_chk #(
   .NARROW_LEN (NARROW_LEN),
   .WIDE_LEN   (WIDE_LEN),
   .SF_FRAMES  (SF_FRAMES),
   .ESF_FRAMES (ESF_FRAMES),
   .PULSE_CYC  (PULSE_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fsync      (fsync),
   .wide_rate  (wide_rate),
   .par_mode   (par_mode),
   .ext_mf     (ext_mf),
   .bit_pos    (bit_pos),
   .chan_bit   (chan_bit),
   .lsb_strobe (lsb_strobe),
   .rd_pos     (rd_pos),
   .rd_adv     (rd_adv),
   .idle_ones  (idle_ones),
   .frame_idx  (frame_idx),
   .mf_pulse   (mf_pulse)
);

// File: tb/slot_timer_tb.sv
module slot_timer_tb;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fsync = 1'b0;
   logic       wide_rate = 1'b0;
   logic       par_mode = 1'b0;
   logic       ext_mf = 1'b0;
   logic       slip_skip = 1'b0;
   logic       slip_rep = 1'b0;
   logic [8:0] bit_pos;
   logic [4:0] chan_idx;
   logic [2:0] chan_bit;
   logic       fbit_slot;
   logic       chan_clk;
   logic       lsb_strobe;
   logic [8:0] rd_pos;
   logic       rd_adv;
   logic       idle_ones;
   logic [4:0] frame_idx;
   logic       mf_pulse;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   slot_timer u_dut (
      .clk(clk), .rst_n(rst_n), .fsync(fsync), .wide_rate(wide_rate),
      .par_mode(par_mode), .ext_mf(ext_mf), .slip_skip(slip_skip), .slip_rep(slip_rep),
      .bit_pos(bit_pos), .chan_idx(chan_idx), .chan_bit(chan_bit), .fbit_slot(fbit_slot),
      .chan_clk(chan_clk), .lsb_strobe(lsb_strobe), .rd_pos(rd_pos), .rd_adv(rd_adv),
      .idle_ones(idle_ones), .frame_idx(frame_idx), .mf_pulse(mf_pulse)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // realign with one frame-sync pulse; ends on the falling edge showing position 0
   task automatic sync_frame();
      @(negedge clk); fsync = 1'b1;
      @(negedge clk); fsync = 1'b0;
      chk("R3", "position after sync", int'(bit_pos), 0);
   endtask

   task automatic wait_for(input int pos, input int fr, input int limit);
      for (int i = 0; i < limit; i++) begin
         if (int'(bit_pos) == pos && (fr < 0 || int'(frame_idx) == fr)) return;
         @(negedge clk);
      end
      chk("R9", "wait target reached", 0, 1);
   endtask

   task automatic slip(input logic sk, input logic rp);
      slip_skip = sk; slip_rep = rp;
      @(negedge clk);
      slip_skip = 1'b0; slip_rep = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1", "bit_pos in reset", int'(bit_pos), 0);
      chk("R1", "frame_idx in reset", int'(frame_idx), 0);
      chk("R1", "mf_pulse in reset", int'(mf_pulse), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2", "first count after reset", int'(bit_pos), 1);
   endtask

   // walk one full frame plus one bit and compare every decoded output
   task automatic t_walk(input logic w, input logic p);
      int len = w ? 256 : 193;
      string rs = w ? "R5" : "R4";
      @(negedge clk); wide_rate = w; par_mode = p;
      sync_frame();
      for (int k = 0; k <= len; k++) begin
         int pp = k % len;
         int ech, ebt, efb, erd, eadv;
         if (pp == 0) begin
            ech = w ? 31 : 0; ebt = w ? 7 : 0; efb = w ? 0 : 1;
         end else begin
            ech = (pp - 1) / 8; ebt = (pp - 1) % 8; efb = 0;
         end
         erd  = p ? (pp + 8) % len : pp;
         eadv = (!w || (erd >= 1 && erd <= 192)) ? 1 : 0;
         chk("R2", "bit_pos", int'(bit_pos), pp);
         chk(rs, "chan_idx", int'(chan_idx), ech);
         chk(rs, "chan_bit", int'(chan_bit), ebt);
         chk(rs, "fbit_slot", int'(fbit_slot), efb);
         chk("R6", "lsb_strobe", int'(lsb_strobe), (efb == 0 && ebt == 7) ? 1 : 0);
         chk("R6", "chan_clk", int'(chan_clk), (efb == 0 && ebt < 4) ? 1 : 0);
         chk("R7", "rd_pos", int'(rd_pos), erd);
         chk("R8", "rd_adv", int'(rd_adv), eadv);
         chk("R8", "idle_ones", int'(idle_ones), 1 - eadv);
         @(negedge clk);
      end
   endtask

   task automatic t_held_sync();
      @(negedge clk); wide_rate = 1'b0; par_mode = 1'b0;
      fsync = 1'b1;
      @(negedge clk);
      chk("R3", "position at held sync", int'(bit_pos), 0);
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk);
         chk("R3", "no realign while held", int'(bit_pos), k);
      end
      fsync = 1'b0;
   endtask

   task automatic t_frame_adv();
      int f0;
      @(negedge clk); ext_mf = 1'b0; wide_rate = 1'b0;
      sync_frame();
      f0 = int'(frame_idx);
      repeat (193) @(negedge clk);
      chk("R9", "frame after wrap", int'(frame_idx), (f0 + 1) % 12);
      repeat (100) @(negedge clk);
      f0 = int'(frame_idx);
      sync_frame();
      chk("R9", "frame after mid-frame realign", int'(frame_idx), (f0 + 1) % 12);
   endtask

   task automatic t_mf(input logic e);
      int mf = e ? 24 : 12;
      int hi = 0;
      @(negedge clk); ext_mf = e; wide_rate = 1'b0;
      sync_frame();
      wait_for(0, mf - 1, 30 * 193);
      repeat (193) @(negedge clk);
      chk("R9", "frame wraps to 0", int'(frame_idx), 0);
      chk("R11", "mf_pulse at frame 0 start", int'(mf_pulse), 1);
      while (mf_pulse && hi < 200) begin
         hi++;
         @(negedge clk);
      end
      chk("R11", "mf_pulse length", hi, 65);
   endtask

   task automatic t_slip();
      int f;
      @(negedge clk); ext_mf = 1'b0; wide_rate = 1'b0;
      sync_frame();
      repeat (50) @(negedge clk);
      f = int'(frame_idx);
      slip(1'b1, 1'b0);
      chk("R10", "skip mid-frame", int'(frame_idx), (f + 1) % 12);
      slip(1'b0, 1'b1);
      chk("R10", "repeat mid-frame", int'(frame_idx), f);
      slip(1'b1, 1'b1);
      chk("R10", "skip and repeat cancel", int'(frame_idx), f);
      wait_for(192, -1, 300);
      f = int'(frame_idx);
      slip(1'b1, 1'b0);
      chk("R10", "skip at frame start position", int'(bit_pos), 0);
      chk("R10", "skip adds to frame start", int'(frame_idx), (f + 2) % 12);
      wait_for(0, 11, 14 * 193);
      repeat (30) @(negedge clk);
      slip(1'b1, 1'b0);
      chk("R10", "skip wraps 11 to 0", int'(frame_idx), 0);
      chk("R11", "no pulse without frame start", int'(mf_pulse), 0);
      slip(1'b0, 1'b1);
      chk("R10", "repeat wraps 0 to 11", int'(frame_idx), 11);
   endtask

   initial begin
      #(CLK_P * 200000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      t_reset();
      t_walk(1'b0, 1'b0);
      t_walk(1'b0, 1'b1);
      t_walk(1'b1, 1'b0);
      t_walk(1'b1, 1'b1);
      t_held_sync();
      t_frame_adv();
      t_mf(1'b0);
      t_mf(1'b1);
      t_slip();
      summary();
      $finish;
   end
endmodule